// File: doc/BRIEF.md
# Programmable Card Clock Divider

This block derives the clock for a memory-card bus from the master clock. A register image supplies an 8-bit divide value together with control bits for enable, bypass, power saving, output-edge selection, hardware flow control and bus width. The block drives the divided card clock and a one-cycle strobe that marks the card-clock edge on which output data should change. It also decodes the selected data bus width for the pad logic.

The parameter `ALT_DIV` chooses between two divide equations. The even equation gives a square wave whose period is 2·(div+1) master cycles. The compact equation gives a period of div+2 master cycles: the clock is high for one master cycle and low for the rest of the period. In bypass, the master clock is passed straight through a glitch-free gate.

The card clock can also be paused. Power saving pauses it while the card bus is idle. Flow control pauses it while the data FIFO cannot keep up. A pause always happens in the low phase, and the clock always resumes with a full-length high phase.

Top module: `card_clk_gen`

## Requirements
- R1: With `ALT_DIV`=0 and bypass clear, the card clock is high for div+1 and low for div+1 master cycles, for every div from 0 to 255.
- R2: With `ALT_DIV`=1 and bypass clear, the card clock is high for exactly 1 master cycle and low for div+1 master cycles, giving a period of div+2.
- R3: With bypass set and enable set, the card clock is high while the master clock is high and low while it is low, whatever the divide value.
- R4: With enable clear, the card clock stays low, both in bypass and in divided mode.
- R5: With power-save set and `bus_busy` low, the divided clock finishes any high phase and then stays low. Once `bus_busy` rises, the next high phase has its full length.
- R6: With flow control enabled and `fifo_stall` high, the divided clock stops in its low phase. When flow control is disabled, `fifo_stall` has no effect.
- R7: A new divide value is taken only at a rising card-clock edge. The high and low phases of the period already in progress keep the old value.
- R8: In divided mode, `cclk_edge` is high for exactly the master cycle in which the card clock has just risen (negedge select clear) or has just fallen (negedge select set). In bypass, it is high in every cycle in which the clock runs.
- R9: `bus_width` is 2 when `cfg_wide8` is set (even if `cfg_wide4` is also set), 1 when only `cfg_wide4` is set, and 0 otherwise.
- R10: During reset, and with all inputs low after reset, `cclk`, `cclk_edge` and `bus_width` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Divide value |
| cfg_en | input | 1 | Clock enable |
| cfg_bypass | input | 1 | Pass master clock through |
| cfg_pwrsave | input | 1 | Stop clock while bus idle |
| cfg_negedge | input | 1 | Strobe marks falling edge |
| cfg_wide4 | input | 1 | Select 4-bit bus |
| cfg_wide8 | input | 1 | Select 8-bit bus |
| cfg_flow_en | input | 1 | Honour FIFO stall |
| bus_busy | input | 1 | Card bus activity request |
| fifo_stall | input | 1 | FIFO cannot accept or supply data |
| cclk | output | 1 | Card clock |
| cclk_edge | output | 1 | Output-edge strobe |
| bus_width | output | 2 | 0: 1-bit, 1: 4-bit, 2: 8-bit |

## Verification
Two events can land in the same master cycle: a divide-value write and the rising edge that latches it. The bench writes the new value in exactly the cycle the card clock goes high. It then checks that the current period completes with the old lengths and that the following high phase uses the new one. A stop request that arrives in the middle of a high phase is judged the same way: the high phase must run to its full length, with no clock activity afterwards, and the first high phase after restart must again be full length.

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int DIV_W   = 8,
  parameter bit ALT_DIV = 1'b0
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_en,
  input  logic             cfg_bypass,
  input  logic             cfg_pwrsave,
  input  logic             cfg_negedge,
  input  logic             cfg_wide4,
  input  logic             cfg_wide8,
  input  logic             cfg_flow_en,
  input  logic             bus_busy,
  input  logic             fifo_stall,
  output logic             cclk,
  output logic             cclk_edge,
  output logic [1:0]       bus_width
);
  logic             div_clk, edge_q, byp_gate, run;
  logic [DIV_W-1:0] cnt, cur_div, hi_len_m1;

  assign run = cfg_en & ~(cfg_pwrsave & ~bus_busy) & ~(cfg_flow_en & fifo_stall);

  generate
    if (ALT_DIV) begin : g_pulse
      assign hi_len_m1 = '0;
    end else begin : g_square
      assign hi_len_m1 = cfg_div;
    end
  endgenerate

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      div_clk <= 1'b0;
      edge_q  <= 1'b0;
      cnt     <= '0;
      cur_div <= '0;
    end else if (!cfg_en || cfg_bypass) begin
      div_clk <= 1'b0;
      edge_q  <= 1'b0;
      cnt     <= '0;
      cur_div <= cfg_div;
    end else begin
      edge_q <= 1'b0;
      if (div_clk || run) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (!div_clk) begin
          div_clk <= 1'b1;
          cur_div <= cfg_div;
          cnt     <= hi_len_m1;
          edge_q  <= ~cfg_negedge;
        end else begin
          div_clk <= 1'b0;
          cnt     <= cur_div;
          edge_q  <= cfg_negedge;
        end
      end
    end
  end

  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) byp_gate <= 1'b0;
    else        byp_gate <= cfg_bypass & run;
  end

  assign cclk      = cfg_bypass ? (mclk & byp_gate) : div_clk;
  assign cclk_edge = cfg_bypass ? byp_gate : edge_q;
  assign bus_width = cfg_wide8 ? 2'd2 : (cfg_wide4 ? 2'd1 : 2'd0);
endmodule

module card_clk_gen_chk (
  input logic mclk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_bypass,
  input logic cfg_pwrsave,
  input logic cfg_negedge,
  input logic cfg_flow_en,
  input logic bus_busy,
  input logic fifo_stall,
  input logic div_clk,
  input logic edge_q
);
  AST_OFF_LOW: assert property (@(posedge mclk) disable iff (!rst_n)
    !cfg_en |=> !div_clk); // R4
  AST_BYPASS_IDLE: assert property (@(posedge mclk) disable iff (!rst_n)
    cfg_bypass |=> !div_clk); // R3
  AST_SAVE_HOLD: assert property (@(posedge mclk) disable iff (!rst_n)
    (cfg_en && cfg_pwrsave && !bus_busy && !div_clk) |=> !div_clk); // R5
  AST_STALL_HOLD: assert property (@(posedge mclk) disable iff (!rst_n)
    (cfg_en && cfg_flow_en && fifo_stall && !div_clk) |=> !div_clk); // R6
  AST_EDGE_PULSE: assert property (@(posedge mclk) disable iff (!rst_n)
    edge_q |=> (!edge_q || cfg_negedge != $past(cfg_negedge))); // R8
endmodule

bind card_clk_gen card_clk_gen_chk u_chk (
  .mclk(mclk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bypass(cfg_bypass),
  .cfg_pwrsave(cfg_pwrsave), .cfg_negedge(cfg_negedge), .cfg_flow_en(cfg_flow_en),
  .bus_busy(bus_busy), .fifo_stall(fifo_stall), .div_clk(div_clk), .edge_q(edge_q)
);

// File: tb/test_card_clk_gen.sv
module test_card_clk_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] div = '0;
  logic en = 0, byp = 0, psave = 0, neg = 0, w4 = 0, w8 = 0, fen = 0, busy = 0, stall = 0;
  logic cs, es, ca, ea;
  logic [1:0] bs, ba;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [2047:0] vs, va, gs, ga;

  // Standard instance: 50% duty. Compact instance: duty 1/(div+2).
  card_clk_gen #(.DIV_W(8), .ALT_DIV(1'b0)) i_card_clk_gen (
    .mclk(clk), .rst_n(rst_n), .cfg_div(div), .cfg_en(en), .cfg_bypass(byp),
    .cfg_pwrsave(psave), .cfg_negedge(neg), .cfg_wide4(w4), .cfg_wide8(w8),
    .cfg_flow_en(fen), .bus_busy(busy), .fifo_stall(stall),
    .cclk(cs), .cclk_edge(es), .bus_width(bs));
  card_clk_gen #(.DIV_W(8), .ALT_DIV(1'b1)) i_card_clk_gen_alt (
    .mclk(clk), .rst_n(rst_n), .cfg_div(div), .cfg_en(en), .cfg_bypass(byp),
    .cfg_pwrsave(psave), .cfg_negedge(neg), .cfg_wide4(w4), .cfg_wide8(w8),
    .cfg_flow_en(fen), .bus_busy(busy), .fifo_stall(stall),
    .cclk(ca), .cclk_edge(ea), .bus_width(ba));

  always #10 clk = ~clk;

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary;
      $finish;
    end
  end

  task automatic tick;
    @(posedge clk); #18;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic record(int n);
    for (int i = 0; i < n; i++) begin
      tick;
      vs[i] = cs; va[i] = ca; gs[i] = es; ga[i] = ea;
    end
  endtask

  function automatic void phases(logic [2047:0] v, int n, output int hi, output int lo);
    int i = 1;
    while (i < n && !(v[i-1] == 1'b0 && v[i] == 1'b1)) i++;
    hi = 0;
    while (i < n && v[i]) begin hi++; i++; end
    lo = 0;
    while (i < n && !v[i]) begin lo++; i++; end
  endfunction

  function automatic int edge_errs(logic [2047:0] v, logic [2047:0] g, int n, bit ng);
    int b = 0;
    for (int i = 1; i < n; i++) begin
      logic e;
      e = ng ? (v[i-1] & ~v[i]) : (~v[i-1] & v[i]);
      if (g[i] !== e) b++;
    end
    return b;
  endfunction

  function automatic int ones(logic [2047:0] v, int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (v[i]) c++;
    return c;
  endfunction

  task automatic restart;
    en = 0; tick; en = 1;
  endtask

  task automatic check_div(int d);
    int n, h, l;
    div = d[7:0];
    neg = 1'($urandom % 2);
    w4 = 1'($urandom % 2);
    w8 = 1'($urandom % 2);
    restart;
    n = 3 * (2 * d + 2) + 6;
    record(n);
    phases(vs, n, h, l);
    chk("R1", "std high", h, d + 1);
    chk("R1", "std low", l, d + 1);
    phases(va, n, h, l);
    chk("R2", "alt high", h, 1);
    chk("R2", "alt low", l, d + 1);
    chk("R8", "std strobe errors", edge_errs(vs, gs, n, neg), 0);
    chk("R8", "alt strobe errors", edge_errs(va, ga, n, neg), 0);
    chk("R9", "width", int'(bs), w8 ? 2 : (w4 ? 1 : 0));
  endtask

  task automatic byp_check(int d);
    div = d[7:0]; byp = 1; en = 1;
    tick; tick;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #5;
      chk("R3", "std clk high", int'(cs), 1);
      chk("R3", "alt clk high", int'(ca), 1);
      chk("R8", "bypass strobe", int'(es), 1);
      #10;
      chk("R3", "std clk low", int'(cs), 0);
      chk("R3", "alt clk low", int'(ca), 0);
      #3;
    end
    byp = 0;
  endtask

  initial begin
    int h, l, h2;
    void'($urandom(32'hC1C0));
    tick; tick;
    chk("R10", "cclk in reset", int'(cs), 0);
    chk("R10", "strobe in reset", int'(es), 0);
    chk("R10", "width in reset", int'(bs), 0);
    rst_n = 1;
    tick; tick;
    chk("R10", "cclk idle", int'(cs | ca), 0);
    chk("R10", "strobe idle", int'(es | ea), 0);
    chk("R10", "width idle", int'(bs | ba), 0);

    // R9 directed combinations
    w4 = 0; w8 = 0; tick; chk("R9", "none", int'(bs), 0);
    w4 = 1; w8 = 0; tick; chk("R9", "wide4", int'(bs), 1);
    w4 = 0; w8 = 1; tick; chk("R9", "wide8", int'(bs), 2);
    w4 = 1; w8 = 1; tick; chk("R9", "both", int'(ba), 2);

    // R1 R2 boundaries and random divide values
    check_div(0);
    check_div(255);
    check_div(1);
    for (int k = 0; k < 24; k++) begin
      int d;
      d = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 12);
      check_div(d);
    end

    // R7: new value written in the cycle the clock rises
    neg = 0; div = 8'd3; restart;
    for (int i = 0; i < 50; i++) begin
      if (cs) break;
      tick;
    end
    div = 8'd1;
    h = 1;
    for (int i = 0; i < 20; i++) begin tick; if (!cs) break; h++; end
    l = 1;
    for (int i = 0; i < 20; i++) begin tick; if (cs) break; l++; end
    h2 = 1;
    for (int i = 0; i < 20; i++) begin tick; if (!cs) break; h2++; end
    chk("R7", "old high kept", h, 4);
    chk("R7", "old low kept", l, 4);
    chk("R7", "new high", h2, 2);

    // R5: power-save stop and clean restart
    div = 8'd2; restart; psave = 1; busy = 1;
    record(11);
    busy = 0;
    for (int i = 0; i < 8; i++) tick;
    record(40);
    chk("R5", "std idle highs", ones(vs, 40), 0);
    chk("R5", "alt idle highs", ones(va, 40), 0);
    chk("R5", "idle strobes", ones(gs, 40) + ones(ga, 40), 0);
    busy = 1;
    record(40);
    phases(vs, 40, h, l);
    chk("R5", "std restart high", h, 3);
    chk("R5", "std restart low", l, 3);
    phases(va, 40, h, l);
    chk("R5", "alt restart high", h, 1);
    psave = 0; busy = 0;

    // R6: flow-control stall, then stall ignored
    restart; fen = 1;
    record(7);
    stall = 1;
    for (int i = 0; i < 8; i++) tick;
    record(40);
    chk("R6", "std stalled highs", ones(vs, 40), 0);
    chk("R6", "alt stalled highs", ones(va, 40), 0);
    fen = 0;
    record(40);
    phases(vs, 40, h, l);
    chk("R6", "stall ignored high", h, 3);
    chk("R6", "stall ignored low", l, 3);
    stall = 0;

    // R4: disabled clock stays low
    en = 0; tick;
    record(30);
    chk("R4", "std off highs", ones(vs, 30), 0);
    chk("R4", "alt off highs", ones(va, 30), 0);
    byp = 1; tick; tick;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #5;
      chk("R4", "bypass off", int'(cs | ca), 0);
      #13;
    end
    byp = 0;

    // R3: bypass follows master clock, divide ignored
    byp_check(7);
    byp_check(200);

    done = 1;
    summary;
    $finish;
  end
endmodule